// File: doc/BRIEF.md
# Warp Reconvergence Stack with Transaction Retry

This block keeps the control-flow state of one warp in a SIMT core. Every stacked path holds a PC, an active lane mask and a 2-bit kind. The entry at the top of the stack supplies the PC and lane mask that the warp scheduler issues next. Ordinary branch divergence pushes plain path entries, and reaching a reconvergence point pops them again.

Hardware transactions add two further kinds of entry. A restart entry holds the first PC of the transaction body. It also collects the lanes that must try again. An attempt entry holds the lanes taking part in the current attempt of the transaction. The validation logic outside this block reports at commit which lanes failed. The stack then re-runs only those lanes from the restart PC. Lanes that committed wait at the code after the commit point. Once every retry has drained, the warp continues there with its full mask from before the transaction.

Conflict detection, memory validation and the commit writes lie outside this block. It receives only the per-lane outcome, and it raises two sticky error flags: one for stack overflow and one for misuse of the event protocol.

Top module: `simt_txn_stack`

## Requirements
- R1: After reset the stack holds one entry. Its kind is path (code 0), its PC is RESET_PC and its mask has every lane set. Both error flags are clear.
- R2: A step event writes its PC into the top entry and leaves the mask and the depth unchanged.
- R3: A divergence with both masks nonzero does three things. It sets the top entry's PC to the reconvergence PC, pushes the not-taken path and then pushes the taken path. The top becomes the taken path (kind 0) and the depth grows by 2. If only one mask is nonzero, nothing is pushed and the top PC becomes that path's target.
- R4: A reconverge event pops a top entry of kind path when the depth is above 1. The entry beneath then continues at its stored PC.
- R5: A transaction begin pushes a restart entry (kind 1, empty mask, restart PC) and then an attempt entry (kind 2, restart PC, copy of the current mask). The depth grows by 2. A restart entry is never on top.
- R6: Divergence inside a transaction pushes path entries above the attempt entry. Reconverging them returns to the attempt entry with its mask unchanged.
- R7: On a commit where some attempt lanes fail, the top stays an attempt entry at the restart PC and the depth does not change. The new mask holds only the failing lanes. Failure bits for lanes outside the attempt mask are ignored. The restart mask returns to empty.
- R8: Every accepted commit writes its after-commit PC into the entry below the restart entry. On a commit with no failing lanes, both transaction entries are popped. The warp then resumes at that PC with the mask it had before the transaction.
- R9: A begin, or a two-path divergence, that would take the depth beyond DEPTH leaves the stack unchanged. It sets the overflow flag, which stays set until reset.
- R10: Two events are protocol errors: a commit while the top is not an attempt entry, and a reconverge while the top is not a path entry or the depth is 1. Either one leaves the stack unchanged and sets a protocol flag that stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_valid | input | 1 | Top entry advances to step_pc |
| step_pc | input | PC_W | Next sequential PC of the top path |
| div_valid | input | 1 | Branch divergence event |
| div_taken_mask | input | LANES | Lanes taking the branch |
| div_taken_pc | input | PC_W | Branch target |
| div_nt_mask | input | LANES | Lanes falling through |
| div_nt_pc | input | PC_W | Fall-through PC |
| div_rpc | input | PC_W | Reconvergence PC of the branch |
| reconv_valid | input | 1 | Top path reached its reconvergence point |
| tx_begin | input | 1 | Transaction begin event |
| tx_restart_pc | input | PC_W | First PC of the transaction body |
| tx_commit | input | 1 | Transaction commit event |
| tx_fail_mask | input | LANES | Lanes that failed validation |
| tx_after_pc | input | PC_W | PC following the commit instruction |
| cur_pc | output | PC_W | PC to issue |
| cur_mask | output | LANES | Active lanes to issue |
| cur_type | output | 2 | Kind of top entry (0 path, 1 restart, 2 attempt) |
| depth | output | $clog2(DEPTH+1) | Number of valid entries |
| ovf_err | output | 1 | Sticky overflow flag |
| proto_err | output | 1 | Sticky protocol-error flag |

## Verification
The assertions assume that at most one event input is high in any cycle. They also assume that divergence masks are disjoint and lie within the current mask, so the top entry never holds an empty mask. The bench keeps to these assumptions: every event is a single-cycle pulse driven apart from the others, and every mask is chosen as a subset of the active lanes. Protocol-error and overflow cases are the only deliberately wrong uses. Neither breaks an assumption the assertions make.

// File: rtl/simt_txn_stack.sv
module simt_txn_stack #(
  parameter int LANES = 8,
  parameter int PC_W = 16,
  parameter int DEPTH = 16,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_valid,
  input  logic [PC_W-1:0]  step_pc,
  input  logic             div_valid,
  input  logic [LANES-1:0] div_taken_mask,
  input  logic [PC_W-1:0]  div_taken_pc,
  input  logic [LANES-1:0] div_nt_mask,
  input  logic [PC_W-1:0]  div_nt_pc,
  input  logic [PC_W-1:0]  div_rpc,
  input  logic             reconv_valid,
  input  logic             tx_begin,
  input  logic [PC_W-1:0]  tx_restart_pc,
  input  logic             tx_commit,
  input  logic [LANES-1:0] tx_fail_mask,
  input  logic [PC_W-1:0]  tx_after_pc,
  output logic [PC_W-1:0]  cur_pc,
  output logic [LANES-1:0] cur_mask,
  output logic [1:0]       cur_type,
  output logic [$clog2(DEPTH+1)-1:0] depth,
  output logic             ovf_err,
  output logic             proto_err
);
  localparam int SP_W = $clog2(DEPTH);
  localparam int DEP_W = $clog2(DEPTH+1);
  localparam logic [1:0] KIND_PATH = 2'd0;
  localparam logic [1:0] KIND_RESTART = 2'd1;
  localparam logic [1:0] KIND_ATTEMPT = 2'd2;

  logic [PC_W-1:0]  pc_q   [DEPTH];
  logic [LANES-1:0] mask_q [DEPTH];
  logic [1:0]       kind_q [DEPTH];
  logic [SP_W-1:0]  sp_q;

  wire [SP_W-1:0] sp_up1 = sp_q + SP_W'(1);
  wire [SP_W-1:0] sp_up2 = sp_q + SP_W'(2);
  wire [SP_W-1:0] sp_dn1 = sp_q - SP_W'(1);
  wire [SP_W-1:0] sp_dn2 = sp_q - SP_W'(2);

  wire room2     = (int'(sp_q) + 2) <= (DEPTH - 1);
  wire top_is_at = kind_q[sp_q] == KIND_ATTEMPT;
  wire commit_ok = tx_commit && top_is_at;
  wire reconv_ok = kind_q[sp_q] == KIND_PATH && sp_q != '0;
  wire two_paths = (|div_taken_mask) && (|div_nt_mask);
  wire [LANES-1:0] retry = mask_q[sp_dn1] | (tx_fail_mask & mask_q[sp_q]);

  assign cur_pc   = pc_q[sp_q];
  assign cur_mask = mask_q[sp_q];
  assign cur_type = kind_q[sp_q];
  assign depth    = DEP_W'(sp_q) + DEP_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        pc_q[i]   <= RESET_PC;
        mask_q[i] <= '1;
        kind_q[i] <= KIND_PATH;
      end
      sp_q      <= '0;
      ovf_err   <= 1'b0;
      proto_err <= 1'b0;
    end else if (tx_commit) begin
      if (!top_is_at) begin
        proto_err <= 1'b1;
      end else begin
        pc_q[sp_dn2] <= tx_after_pc;
        if (|retry) begin
          mask_q[sp_q]   <= retry;
          pc_q[sp_q]     <= pc_q[sp_dn1];
          mask_q[sp_dn1] <= '0;
        end else begin
          sp_q <= sp_dn2;
        end
      end
    end else if (tx_begin) begin
      if (!room2) begin
        ovf_err <= 1'b1;
      end else begin
        pc_q[sp_up1]   <= tx_restart_pc;
        mask_q[sp_up1] <= '0;
        kind_q[sp_up1] <= KIND_RESTART;
        pc_q[sp_up2]   <= tx_restart_pc;
        mask_q[sp_up2] <= mask_q[sp_q];
        kind_q[sp_up2] <= KIND_ATTEMPT;
        sp_q           <= sp_up2;
      end
    end else if (div_valid) begin
      if (two_paths) begin
        if (!room2) begin
          ovf_err <= 1'b1;
        end else begin
          pc_q[sp_q]     <= div_rpc;
          pc_q[sp_up1]   <= div_nt_pc;
          mask_q[sp_up1] <= div_nt_mask;
          kind_q[sp_up1] <= KIND_PATH;
          pc_q[sp_up2]   <= div_taken_pc;
          mask_q[sp_up2] <= div_taken_mask;
          kind_q[sp_up2] <= KIND_PATH;
          sp_q           <= sp_up2;
        end
      end else if (|div_taken_mask) begin
        pc_q[sp_q] <= div_taken_pc;
      end else if (|div_nt_mask) begin
        pc_q[sp_q] <= div_nt_pc;
      end
    end else if (reconv_valid) begin
      if (reconv_ok) sp_q <= sp_dn1;
      else proto_err <= 1'b1;
    end else if (step_valid) begin
      pc_q[sp_q] <= step_pc;
    end
  end

  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({step_valid, div_valid, reconv_valid, tx_begin, tx_commit})); // R10
  AST_TOP_SANE: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_type != KIND_RESTART) && (cur_mask != '0)); // R5
  AST_BEGIN_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_begin && room2) |=> (cur_type == KIND_ATTEMPT && depth == $past(depth) + 2'd2)); // R5
  AST_RETRY_LOOP: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_ok && (|retry)) |=> (cur_type == KIND_ATTEMPT && $stable(depth)
      && (cur_mask & ~$past(cur_mask)) == '0)); // R7
  AST_COMMIT_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_ok && retry == '0) |=> (depth == $past(depth) - 2'd2 && cur_pc == $past(tx_after_pc))); // R8
  AST_RECONV_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (reconv_valid && reconv_ok) |=> (depth == $past(depth) - 1'b1)); // R4
  AST_BAD_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_commit && !top_is_at) |=> (proto_err && $stable(depth))); // R10
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |=> ovf_err); // R9
  AST_PROTO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err); // R10
endmodule

// File: tb/simt_txn_stack_test.sv
module simt_txn_stack_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic step_valid = 0, div_valid = 0, reconv_valid = 0, tx_begin = 0, tx_commit = 0;
  logic [15:0] step_pc = '0, div_taken_pc = '0, div_nt_pc = '0, div_rpc = '0;
  logic [15:0] tx_restart_pc = '0, tx_after_pc = '0;
  logic [7:0] div_taken_mask = '0, div_nt_mask = '0, tx_fail_mask = '0;
  logic [15:0] cur_pc;
  logic [7:0] cur_mask;
  logic [1:0] cur_type;
  logic [4:0] depth;
  logic ovf_err, proto_err;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  simt_txn_stack uut (.*);

  task automatic chk(string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", what, got, exp);
    end
  endtask

  task automatic top(string req, logic [15:0] pc, logic [7:0] m, logic [1:0] k, int d);
    chk({req, " pc"}, 32'(cur_pc), 32'(pc));
    chk({req, " mask"}, 32'(cur_mask), 32'(m));
    chk({req, " kind"}, 32'(cur_type), 32'(k));
    chk({req, " depth"}, 32'(depth), 32'(d));
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  task automatic do_step(logic [15:0] pc);
    @(negedge clk); step_valid = 1; step_pc = pc;
    @(negedge clk); step_valid = 0;
  endtask

  task automatic do_div(logic [7:0] tm, logic [15:0] tp, logic [7:0] nm, logic [15:0] np, logic [15:0] rp);
    @(negedge clk); div_valid = 1; div_taken_mask = tm; div_taken_pc = tp;
    div_nt_mask = nm; div_nt_pc = np; div_rpc = rp;
    @(negedge clk); div_valid = 0;
  endtask

  task automatic do_reconv();
    @(negedge clk); reconv_valid = 1;
    @(negedge clk); reconv_valid = 0;
  endtask

  task automatic do_begin(logic [15:0] rp);
    @(negedge clk); tx_begin = 1; tx_restart_pc = rp;
    @(negedge clk); tx_begin = 0;
  endtask

  task automatic do_commit(logic [7:0] f, logic [15:0] ap);
    @(negedge clk); tx_commit = 1; tx_fail_mask = f; tx_after_pc = ap;
    @(negedge clk); tx_commit = 0;
  endtask

  task automatic t_reset();
    do_reset();
    top("R1", 16'h0, 8'hFF, 2'd0, 1);
    chk("R1 ovf", 32'(ovf_err), 0);
    chk("R1 proto", 32'(proto_err), 0);
  endtask

  task automatic t_reference();
    do_reset();
    do_step(16'h4);
    top("R2 step", 16'h4, 8'hFF, 2'd0, 1);
    do_div(8'hCF, 16'h10, 8'h30, 16'h40, 16'h40);
    top("R3 diverge", 16'h10, 8'hCF, 2'd0, 3);
    do_begin(16'h11);
    top("R5 begin", 16'h11, 8'hCF, 2'd2, 5);
    do_div(8'h0F, 16'h20, 8'hC0, 16'h28, 16'h30);
    top("R6 inner taken", 16'h20, 8'h0F, 2'd0, 7);
    do_reconv();
    top("R6 inner fallthrough", 16'h28, 8'hC0, 2'd0, 6);
    do_reconv();
    top("R6 back at attempt", 16'h30, 8'hCF, 2'd2, 5);
    do_commit(8'hF0, 16'h38);
    top("R7 first fail", 16'h11, 8'hC0, 2'd2, 5);
    do_commit(8'hC0, 16'h38);
    top("R7 retry fails again", 16'h11, 8'hC0, 2'd2, 5);
    do_commit(8'h80, 16'h38);
    top("R7 retry partial", 16'h11, 8'h80, 2'd2, 5);
    do_commit(8'h00, 16'h38);
    top("R8 drained", 16'h38, 8'hCF, 2'd0, 3);
    do_reconv();
    top("R4 pop to fallthrough", 16'h40, 8'h30, 2'd0, 2);
    do_reconv();
    top("R4 pop to bottom", 16'h40, 8'hFF, 2'd0, 1);
    chk("R10 no spurious proto", 32'(proto_err), 0);
  endtask

  task automatic t_single_path();
    do_reset();
    do_div(8'h00, 16'h50, 8'hFF, 16'h54, 16'h60);
    top("R3 not-taken only", 16'h54, 8'hFF, 2'd0, 1);
    do_div(8'hFF, 16'h70, 8'h00, 16'h74, 16'h80);
    top("R3 taken only", 16'h70, 8'hFF, 2'd0, 1);
  endtask

  task automatic t_first_pass();
    do_reset();
    do_begin(16'h5);
    top("R5 begin at bottom", 16'h5, 8'hFF, 2'd2, 3);
    do_commit(8'h00, 16'h9);
    top("R8 all commit", 16'h9, 8'hFF, 2'd0, 1);
  endtask

  task automatic t_overflow();
    do_reset();
    for (int i = 0; i < 7; i++) do_begin(16'(i + 1));
    top("R9 filled", 16'h7, 8'hFF, 2'd2, 15);
    chk("R9 no ovf yet", 32'(ovf_err), 0);
    do_begin(16'h99);
    top("R9 begin ignored", 16'h7, 8'hFF, 2'd2, 15);
    chk("R9 ovf set", 32'(ovf_err), 1);
    do_div(8'h0F, 16'hA0, 8'hF0, 16'hA4, 16'hA8);
    top("R9 div ignored", 16'h7, 8'hFF, 2'd2, 15);
    do_step(16'h8);
    chk("R9 ovf sticky", 32'(ovf_err), 1);
  endtask

  task automatic t_protocol();
    do_reset();
    do_reconv();
    top("R10 reconv at bottom", 16'h0, 8'hFF, 2'd0, 1);
    chk("R10 proto reconv", 32'(proto_err), 1);
    do_reset();
    do_commit(8'h00, 16'h20);
    top("R10 commit outside tx", 16'h0, 8'hFF, 2'd0, 1);
    chk("R10 proto commit", 32'(proto_err), 1);
    do_reset();
    do_begin(16'h3);
    do_div(8'h01, 16'h8, 8'hFE, 16'h9, 16'hA);
    do_commit(8'hFF, 16'h20);
    top("R10 commit over path entry", 16'h8, 8'h01, 2'd0, 5);
    chk("R10 proto nested", 32'(proto_err), 1);
    do_reset();
    do_begin(16'h3);
    do_reconv();
    top("R10 reconv on attempt", 16'h3, 8'hFF, 2'd2, 3);
    chk("R10 proto attempt", 32'(proto_err), 1);
  endtask

  initial begin
    t_reset();
    t_reference();
    t_single_path();
    t_first_pass();
    t_overflow();
    t_protocol();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule